// File: doc/BRIEF.md
# Nonvolatile-Backed SRAM Mode and Hardware-Store Controller

This block turns the asynchronous control pins of a small battery-free static memory into operating modes. The pins are chip select, write strobe, output enable and a hardware-store request, all active low. The block holds the working SRAM and a shadow nonvolatile copy of it. Reads and writes reach the SRAM through ordinary pin decoding. A pulled-low store request copies the SRAM into the shadow array, but only if something has been written since the last nonvolatile event. After that the part stays locked out until the request pin is let go.

A write flag marks the SRAM as modified. Any accepted write sets it. It is cleared when a store finishes, and also by reset, because reset acts as a power cycle and reloads the SRAM from the shadow copy. The store takes a programmable number of clock cycles. During that time `busy` is high and the data bus is not driven. A shadow array that has never been stored to holds a fixed factory fill word.

The control state machine has three states. RUN handles normal access. STORE is the timed copy. HOLD is the lockout. Its transitions are as follows. RUN goes to STORE when the request arrives and the flag is set. RUN goes straight to HOLD when the request arrives and the flag is clear. STORE goes to HOLD when the busy count runs out. HOLD goes back to RUN when the synchronised request is released.

Top module: `nvs_mode_ctrl`

## Requirements
- R1: With `ce_n` high the block is in standby: `dout_en` is 0 and no SRAM word changes, even with `we_n` low. After reset `dout_en`, `busy` and `locked` are all 0.
- R2: In RUN with `ce_n`=0, `we_n`=1 and `oe_n`=0, `dout_en` is 1 and `dout` shows the word at `addr` in the same cycle. With `oe_n`=1 the bus is not driven.
- R3: In RUN, `ce_n`=0 with `we_n`=0 writes `din` to `addr` on the rising edge, and `dout_en` stays 0 during the write.
- R4: `hw_store_n` passes through a two-flop synchroniser. When the pin falls, STORE (`busy`=1) is first visible after the third rising edge.
- R5: A request made while the write flag is set snapshots the whole SRAM into the shadow array. It holds `busy` high for exactly STORE_CYCLES cycles, then enters HOLD with the flag cleared.
- R6: A request made while the write flag is clear starts no store. `busy` never rises and `locked` rises after the third rising edge.
- R7: In HOLD (`locked`=1) every read and write is ignored: the bus is not driven and memory is unchanged. `locked` falls after the third rising edge following the rise of `hw_store_n`.
- R8: While `busy` is 1, `dout_en` is 0 whatever the pins do.
- R9: Whether a store starts does not depend on `oe_n`.
- R10: The write flag is set by every accepted write. It is cleared by store completion and by reset, so a second request with no writes in between is skipped.
- R11: Reset reloads every SRAM word from the shadow array. Before any store this gives the fill word (0xA5 by default). Writes made after the last store are lost.
- R12: Once the synchronised request is active in RUN, pin accesses are ignored. A write presented in that cycle reaches neither the SRAM nor the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as a power cycle (recall) |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| hw_store_n | input | 1 | Asynchronous hardware-store request, active low |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |
| busy | output | 1 | Store in progress |
| locked | output | 1 | Lockout after a store request |

## Verification
The bench measures where `busy` and `locked` begin and how long they last. A synchroniser with the wrong depth, or an off-by-one busy counter, shifts or stretches those windows. It issues a second request with no writes in between, and a request after reset. A design that ignores the write flag would start a store there and raise `busy`. It attempts writes during the lockout and in the cycle where the request has been seen but the state has not yet moved. A design that lets those through would change data that is read back later or recalled. Finally it resets after unsaved writes, which shows whether the snapshot captured the right contents and whether a recall really happens.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STORE = 2'd1,
        ST_HOLD  = 2'd2
    } nvs_state_e;
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nvs_mem.sv
module nvs_mem #(
    parameter int               WIDTH = 8,
    parameter int               DEPTH = 16,
    parameter logic [WIDTH-1:0] FILL  = 8'hA5,
    localparam int              AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             snap,
    output logic [WIDTH-1:0] rdata
);
    // Working array and its nonvolatile shadow; the shadow keeps its
    // contents across reset and starts out holding the factory fill.
    logic [WIDTH-1:0] sram   [DEPTH];
    logic [WIDTH-1:0] shadow [DEPTH] = '{default: FILL};

    // Reset models a power cycle: every word is recalled from the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sram[i] <= shadow[i];
        end else if (wr_en) begin
            sram[addr] <= wdata;
        end
    end

    // Whole-array snapshot taken on the edge that enters the store.
    always_ff @(posedge clk) begin
        if (rst_n && snap) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] <= sram[i];
        end
    end

    assign rdata = sram[addr];
endmodule

// File: rtl/nvs_fsm.sv
module nvs_fsm
    import nvs_pkg::*;
#(
    parameter int STORE_CYCLES = 8,
    localparam int CW          = $clog2(STORE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic hs_req,
    output logic wr_en,
    output logic drive_en,
    output logic snap,
    output logic busy,
    output logic locked
);
    nvs_state_e    state, state_nxt;
    logic [CW-1:0] cnt;
    logic          dirty;
    logic          access_ok;

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:   if (hs_req) state_nxt = dirty ? ST_STORE : ST_HOLD;
            ST_STORE: if (cnt == '0) state_nxt = ST_HOLD;
            ST_HOLD:  if (!hs_req) state_nxt = ST_RUN;
            default:  state_nxt = ST_RUN;
        endcase
    end

    // State register with the busy counter and write flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
            dirty <= 1'b0;
        end else begin
            state <= state_nxt;
            if (snap)                       cnt <= CW'(STORE_CYCLES - 1);
            else if (state == ST_STORE)     cnt <= cnt - CW'(1);
            if (wr_en)                      dirty <= 1'b1;
            else if (state == ST_STORE && cnt == '0) dirty <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        access_ok = (state == ST_RUN) && !hs_req;
        wr_en     = access_ok && !ce_n && !we_n;
        drive_en  = access_ok && !ce_n && we_n && !oe_n;
        snap      = (state == ST_RUN) && hs_req && dirty;
        busy      = (state == ST_STORE);
        locked    = (state == ST_HOLD);
    end

    assert_write_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dirty);
    assert_dirty_request_stores_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && hs_req && dirty) |=> (state == ST_STORE));
    assert_clean_request_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && hs_req && !dirty) |=> (state == ST_HOLD));
    assert_store_end_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && cnt == '0) |=> (state == ST_HOLD && !dirty));
    assert_hold_while_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hs_req) |=> (state == ST_HOLD));
endmodule

// File: rtl/nvs_mode_ctrl.sv
module nvs_mode_ctrl #(
    parameter int               WIDTH        = 8,
    parameter int               DEPTH        = 16,
    parameter int               STORE_CYCLES = 8,
    parameter int               SYNC_STAGES  = 2,
    parameter logic [WIDTH-1:0] FILL         = 8'hA5,
    localparam int              AW           = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             hw_store_n,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             busy,
    output logic             locked
);
    logic             hs_sync_n;
    logic             hs_req;
    logic             wr_en;
    logic             drive_en;
    logic             snap;
    logic [WIDTH-1:0] rdata;

    nvs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hw_store_n),
        .q     (hs_sync_n)
    );

    assign hs_req = !hs_sync_n;

    nvs_fsm #(.STORE_CYCLES(STORE_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .hs_req   (hs_req),
        .wr_en    (wr_en),
        .drive_en (drive_en),
        .snap     (snap),
        .busy     (busy),
        .locked   (locked)
    );

    nvs_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .FILL(FILL)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (din),
        .snap  (snap),
        .rdata (rdata)
    );

    assign dout_en = drive_en;
    assign dout    = drive_en ? rdata : '0;

    assert_bus_quiet_in_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dout_en);
    assert_store_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(hs_req));
    assert_no_write_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked || busy) |-> !wr_en);
    assert_sync_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req |-> !$past(hw_store_n, 2));
endmodule

// File: tb/tb_nvs_mode_ctrl.sv
`timescale 1ns/1ps
module tb_nvs_mode_ctrl;
    localparam int         W    = 8;
    localparam int         D    = 16;
    localparam int         SC   = 8;
    localparam int         AW   = $clog2(D);
    localparam logic [W-1:0] FILL = 8'hA5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hs_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;
    logic          dout_en, busy, locked;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [W-1:0] exp_sram   [D];
    logic [W-1:0] exp_shadow [D];

    always #2.5 clk = ~clk;

    nvs_mode_ctrl #(.WIDTH(W), .DEPTH(D), .STORE_CYCLES(SC), .SYNC_STAGES(2), .FILL(FILL)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .hw_store_n(hs_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .busy(busy), .locked(locked)
    );

    function automatic bit exp_drive(input logic c, input logic w, input logic o);
        return !c && w && !o;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        cyc(); ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a; #1;
        chk(dout_en === 1'b1 && dout === exp_sram[a], tag, {dout_en, 8'h0, dout}, {1'b1, 8'h0, exp_sram[a]});
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] v);
        cyc(); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = v; #1;
        chk(dout_en === 1'b0, "R3 bus idle during write", dout_en, 0);
        exp_sram[a] = v;
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < D; i++) rd(AW'(i), tag);
    endtask

    task automatic hw_store(input bit want, input logic oe_val, input bit inject,
                            input logic [AW-1:0] ia, input logic [W-1:0] iv);
        int  first_busy = 0;
        int  n_busy     = 0;
        int  first_lock = 0;
        bit  bus_bad    = 0;
        cyc(); hs_n = 1'b0; ce_n = 1'b0; we_n = 1'b1; oe_n = oe_val; addr = AW'($urandom);
        if (want) exp_shadow = exp_sram;
        for (int k = 1; k <= SC + 8; k++) begin
            cyc(); #1;
            if (busy) begin
                n_busy++;
                if (first_busy == 0) first_busy = k;
                if (dout_en) bus_bad = 1;
            end
            if (locked && first_lock == 0) first_lock = k;
            if (inject && k == 2) begin ce_n = 1'b0; we_n = 1'b0; addr = ia; din = iv; end
            if (inject && k == 3) begin we_n = 1'b1; end
        end
        chk(!bus_bad, "R8 bus driven while busy", bus_bad, 0);
        if (want) begin
            chk(n_busy == SC, "R5 busy length", n_busy, SC);
            chk(first_busy == 3, "R4 store start edge", first_busy, 3);
            chk(first_lock == 3 + SC, "R5 lock after store", first_lock, 3 + SC);
            chk(n_busy > 0, "R9 store starts for oe_n level", oe_val, 0);
        end else begin
            chk(n_busy == 0, "R6 no store when clean", n_busy, 0);
            chk(first_lock == 3, "R6 lock edge when clean", first_lock, 3);
        end
        chk(locked === 1'b1 && dout_en === 1'b0, "R7 held locked", {locked, dout_en}, 2'b10);
    endtask

    task automatic release_req();
        cyc(); hs_n = 1'b1; idle();
        for (int k = 1; k <= 3; k++) begin
            cyc(); #1;
            if (k == 2) chk(locked === 1'b1, "R7 still locked", locked, 1);
            if (k == 3) chk(locked === 1'b0, "R7 lock released", locked, 0);
        end
    endtask

    task automatic do_reset();
        cyc(); rst_n = 1'b0; idle(); hs_n = 1'b1;
        repeat (3) cyc();
        rst_n = 1'b1;
        exp_sram = exp_shadow;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R4 watchdog expired act=1 exp=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < D; i++) begin exp_sram[i] = FILL; exp_shadow[i] = FILL; end
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc(); #1;
        chk(dout_en === 1'b0 && busy === 1'b0 && locked === 1'b0, "R1 reset outputs",
            {dout_en, busy, locked}, 0);

        rd_all("R11 factory fill");

        // Standby with write strobe low must not write
        cyc(); ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = 3; din = 8'h00; #1;
        chk(dout_en === 1'b0, "R1 standby bus", dout_en, 0);
        rd(3, "R1 standby no write");

        // Random mix of reads, writes, standby
        for (int n = 0; n < 300; n++) begin
            logic c, w, o;
            logic [AW-1:0] a;
            logic [W-1:0]  v;
            c = ($urandom % 4) == 0; w = $urandom % 2; o = ($urandom % 4) == 0;
            a = AW'($urandom); v = W'($urandom);
            cyc(); ce_n = c; we_n = w; oe_n = o; addr = a; din = v; #1;
            if (exp_drive(c, w, o))
                chk(dout_en === 1'b1 && dout === exp_sram[a], "R2 random read", dout, exp_sram[a]);
            else
                chk(dout_en === 1'b0, c ? "R1 random standby" : "R3 random no drive", dout_en, 0);
            if (!c && !w) exp_sram[a] = v;
        end
        wr(5, 8'h3C);
        rd(5, "R3 directed write");

        // Dirty store with oe_n high
        hw_store(1'b1, 1'b1, 1'b0, '0, '0);
        cyc(); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 0; din = ~exp_sram[0]; #1;
        chk(dout_en === 1'b0, "R7 write in lockout", dout_en, 0);
        cyc(); we_n = 1'b1; oe_n = 1'b0; #1;
        chk(dout_en === 1'b0, "R7 read in lockout", dout_en, 0);
        release_req();
        rd_all("R7 lockout left memory unchanged");

        // Second request without writes is skipped
        hw_store(1'b0, 1'b0, 1'b0, '0, '0);
        release_req();

        // Dirty store with reads active and oe_n low
        wr(2, 8'h5A);
        hw_store(1'b1, 1'b0, 1'b0, '0, '0);
        release_req();
        rd(2, "R10 data kept after store");

        // Write in the cycle the request is seen is discarded
        wr(7, 8'h11);
        hw_store(1'b1, 1'b1, 1'b1, 7, 8'hEE);
        release_req();
        rd(7, "R12 pending write blocked");

        // Unsaved write lost over reset, snapshot recalled
        wr(9, 8'h77);
        do_reset();
        rd_all("R11 recall after reset");
        rd(7, "R12 snapshot excluded pending write");

        // Reset cleared the write flag
        hw_store(1'b0, 1'b1, 1'b0, '0, '0);
        release_req();
        rd(9, "R10 flag cleared by reset");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule